// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Channel Array

A bank of capture/compare channels shares one free-running up-counter. Each channel has its own mode word, which makes it a capture unit, a software timer, a toggling compare output, or an 8-bit pulse-width modulator. In capture mode the counter value is stored when the synchronised channel pin shows a chosen edge. The two compare modes raise a flag when the counter equals the channel value, and one of them also flips the pin. In PWM mode the pin level comes from comparing the counter's low half with the channel's low byte. The new duty byte is taken from the high byte each time the low half of the counter rolls over, so a duty change never cuts a pulse short.

Software reaches the block through a flat register port. A write strobe, an address and write data update a register on the clock edge. Read data follows the address combinationally. Every channel flag and the counter overflow flag feed one interrupt line. The line passes through a per-source enable, a block-level enable and a global enable input.

Top module: `ccu_array`

## Requirements
- R1: While the run bit (control register bit 0, address 0) is 1, the counter (readable at address 12) goes up by one per clock. While the run bit is 0 it holds. A step from 0xFFFF to 0x0000 sets the overflow flag, which is bit 5 of the flag register at address 1.
- R2: Capture is selected when mode bits [5:2] are 0000 and at least one of bit 0 (rising) or bit 1 (falling) is set. Setting both bits captures on either edge. The pin passes through a two-flop synchroniser, then one more stage for edge detection. On a qualifying edge the current counter value is loaded into the channel value register and the channel flag is set. Mode words live at addresses 2 to 6, and channel values at addresses 7 to 11.
- R3: Mode bits [5:0] = 001100 select the timer. When the counter is running and equals the channel value, the channel flag is set on the next edge.
- R4: Mode bits [5:0] = 011100 select the toggle output. On each match, the channel pin inverts and the flag is set. The output enable is 1.
- R5: Mode bits [5:0] = 100100 select PWM. The pin is 0 while the counter's low byte is below the value's low byte, and 1 otherwise. When the running counter's low byte is 0xFF, the value's high byte is copied into its low byte.
- R6: The irq output is 1 exactly when the global enable input and the block enable (control bit 2) are both 1, and some flag is 1 with its own enable set. Mode bit 6 enables a channel flag, and control bit 1 enables the overflow flag.
- R7: Any other mode word leaves the channel idle: no pin drive, output low, and no flag set. Mode bit 6 never changes which mode is selected.
- R8: Flag register bits [4:0] hold the channel flags. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clear wins. A capture or PWM reload also wins over a write to the channel value.
- R9: After reset every register reads 0, no pin is driven, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for writes and reads |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| gie | input | 1 | Global interrupt enable |
| ch_pin_in | input | NCH | Channel pins, asynchronous |
| ch_pin_out | output | NCH | Channel pin output levels |
| ch_pin_oe | output | NCH | Channel pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: five channels, a 16-bit counter and a 4-bit address. With a full 16-bit counter, a complete wrap from 0xFFFF fits within the run, so the overflow flag and its gating are checked on the real width. The PWM byte reload fires every 256 cycles, so several duty periods and a deferred duty change can be observed. Five channels let capture, timer, toggle, PWM and idle channels run at the same time on one counter.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  localparam int MODE_W = 7;

  // bit 6 irq enable, 5 pwm, 4 toggle, 3 match, 2 compare enable, 1 falling, 0 rising
  typedef struct packed {
    logic irq_en;
    logic pwm;
    logic toggle;
    logic match;
    logic cmp_en;
    logic cap_neg;
    logic cap_pos;
  } mode_t;

  typedef enum logic [2:0] {
    CH_IDLE, CH_CAPTURE, CH_TIMER, CH_TOGGLE, CH_PWM
  } ch_kind_e;

  function automatic ch_kind_e decode_mode(mode_t m);
    ch_kind_e k;
    logic     no_cap;
    no_cap = !m.cap_pos && !m.cap_neg;
    k = CH_IDLE;
    if (!m.cmp_en && !m.match && !m.toggle && !m.pwm && !no_cap)
      k = CH_CAPTURE;
    else if (m.cmp_en && m.match && !m.toggle && !m.pwm && no_cap)
      k = CH_TIMER;
    else if (m.cmp_en && m.match && m.toggle && !m.pwm && no_cap)
      k = CH_TOGGLE;
    else if (m.cmp_en && m.pwm && !m.match && !m.toggle && no_cap)
      k = CH_PWM;
    return k;
  endfunction

endpackage

// File: rtl/ccu_timebase.sv
module ccu_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d;
  logic             wrap;

  always_comb begin
    wrap  = run && (cnt_q == {CNT_W{1'b1}});
    cnt_d = run ? cnt_q + 1'b1 : cnt_q;
    ovf_d = wrap ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
  import ccu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             run,
  input  logic             pin_in,
  input  logic             mode_we,
  input  logic             val_we,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] wdata,
  output mode_t            mode_q,
  output logic [CNT_W-1:0] val_q,
  output logic             flag_q,
  output logic             pin_out,
  output logic             pin_oe
);
  localparam int PWM_W = CNT_W / 2;

  mode_t            mode_d;
  logic [CNT_W-1:0] val_d;
  logic             flag_d, tog_q, tog_d;
  logic [2:0]       sync_q, sync_d;
  ch_kind_e         kind;
  logic             rise, fall, cap_hit, cmp_hit, reload, pwm_lvl;

  always_comb begin
    kind    = decode_mode(mode_q);
    rise    = sync_q[1] && !sync_q[2];
    fall    = !sync_q[1] && sync_q[2];
    cap_hit = (kind == CH_CAPTURE) &&
              ((mode_q.cap_pos && rise) || (mode_q.cap_neg && fall));
    cmp_hit = ((kind == CH_TIMER) || (kind == CH_TOGGLE)) && run && (cnt == val_q);
    reload  = (kind == CH_PWM) && run && (cnt[PWM_W-1:0] == {PWM_W{1'b1}});
    pwm_lvl = cnt[PWM_W-1:0] >= val_q[PWM_W-1:0];

    val_d = val_q;
    if (cap_hit)      val_d = cnt;
    else if (reload)  val_d = {val_q[CNT_W-1:PWM_W], val_q[CNT_W-1:PWM_W]};
    else if (val_we)  val_d = wdata;

    mode_d = mode_we ? mode_t'(wdata[MODE_W-1:0]) : mode_q;
    flag_d = (cap_hit || cmp_hit) ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
    tog_d  = ((kind == CH_TOGGLE) && cmp_hit) ? !tog_q : tog_q;
    sync_d = {sync_q[1:0], pin_in};

    pin_oe  = (kind == CH_TOGGLE) || (kind == CH_PWM);
    pin_out = (kind == CH_PWM) ? pwm_lvl : ((kind == CH_TOGGLE) ? tog_q : 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      val_q  <= '0;
      flag_q <= 1'b0;
      tog_q  <= 1'b0;
      sync_q <= '0;
    end else begin
      mode_q <= mode_d;
      val_q  <= val_d;
      flag_q <= flag_d;
      tog_q  <= tog_d;
      sync_q <= sync_d;
    end
  end
endmodule

// File: rtl/ccu_irq_gate.sv
module ccu_irq_gate #(
  parameter int NSRC = 6
) (
  input  logic [NSRC-1:0] src_flag,
  input  logic [NSRC-1:0] src_en,
  input  logic            blk_en,
  input  logic            gie,
  output logic            irq
);
  always_comb irq = gie && blk_en && (|(src_flag & src_en));
endmodule

// File: rtl/ccu_array.sv
module ccu_array
  import ccu_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              gie,
  input  logic [NCH-1:0]    ch_pin_in,
  output logic [NCH-1:0]    ch_pin_out,
  output logic [NCH-1:0]    ch_pin_oe,
  output logic              irq
);
  localparam int CTRL_ADDR = 0;
  localparam int FLAG_ADDR = 1;
  localparam int MODE_BASE = 2;
  localparam int VAL_BASE  = MODE_BASE + NCH;
  localparam int CNT_ADDR  = VAL_BASE + NCH;
  localparam int RUN_BIT = 0, OVF_IE_BIT = 1, BLK_IE_BIT = 2;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [2:0]       ctrl_q, ctrl_d;
  logic             flag_wr;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [NCH-1:0]   ch_flag, ch_ie;
  mode_t            mode_q [NCH];
  logic [CNT_W-1:0] val_q  [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    flag_wr = bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));
    ctrl_d  = (bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR))) ? bus_wdata[2:0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= '0;
    else             ctrl_q <= ctrl_d;
  end

  ccu_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (ctrl_q[RUN_BIT]),
    .ovf_clr (flag_wr && !bus_wdata[NCH]),
    .cnt_q   (cnt_q),
    .ovf_q   (ovf_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ccu_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cnt      (cnt_q),
      .run      (ctrl_q[RUN_BIT]),
      .pin_in   (ch_pin_in[g]),
      .mode_we  (bus_wr && (bus_addr == ADDR_W'(MODE_BASE + g))),
      .val_we   (bus_wr && (bus_addr == ADDR_W'(VAL_BASE + g))),
      .flag_clr (flag_wr && !bus_wdata[g]),
      .wdata    (bus_wdata),
      .mode_q   (mode_q[g]),
      .val_q    (val_q[g]),
      .flag_q   (ch_flag[g]),
      .pin_out  (ch_pin_out[g]),
      .pin_oe   (ch_pin_oe[g])
    );
    assign ch_ie[g] = mode_q[g].irq_en;
  end

  ccu_irq_gate #(.NSRC(NCH + 1)) u_irq (
    .src_flag ({ovf_q, ch_flag}),
    .src_en   ({ctrl_q[OVF_IE_BIT], ch_ie}),
    .blk_en   (ctrl_q[BLK_IE_BIT]),
    .gie      (gie),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata[2:0]   = ctrl_q;
    if (bus_addr == ADDR_W'(FLAG_ADDR)) bus_rdata[NCH:0] = {ovf_q, ch_flag};
    if (bus_addr == ADDR_W'(CNT_ADDR))  bus_rdata        = cnt_q;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(MODE_BASE + i)) bus_rdata[MODE_W-1:0] = mode_q[i];
      if (bus_addr == ADDR_W'(VAL_BASE + i))  bus_rdata = val_q[i];
    end
  end
endmodule

// File: rtl/ccu_array_chk.sv
module ccu_array_chk #(
  parameter int NCH       = 5,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic              ovf_flag,
  input logic [NCH-1:0]    ch_flag,
  input logic              blk_ie,
  input logic              gie,
  input logic              irq,
  input logic [NCH-1:0]    pin_out,
  input logic [NCH-1:0]    pin_oe,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && (cnt != {CNT_W{1'b1}}) |=> cnt == $past(cnt) + 1'b1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt)); // R1
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    run && (cnt == {CNT_W{1'b1}}) |=> ovf_flag); // R1
  AST_IRQ_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq); // R6
  AST_IRQ_BLK: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_ie |-> !irq); // R6
  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR)))
      |=> (($past({ovf_flag, ch_flag}) & ~{ovf_flag, ch_flag}) == '0)); // R8
endmodule

bind ccu_array ccu_array_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .run      (ctrl_q[RUN_BIT]),
  .cnt      (cnt_q),
  .ovf_flag (ovf_q),
  .ch_flag  (ch_flag),
  .blk_ie   (ctrl_q[BLK_IE_BIT]),
  .gie      (gie),
  .irq      (irq),
  .pin_out  (ch_pin_out),
  .pin_oe   (ch_pin_oe),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr)
);

// File: tb/test_ccu_array.sv
`timescale 1ns/100ps
module test_ccu_array;
  localparam int NCH = 5;
  localparam int CW  = 16;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          gie = 1'b0;
  logic [NCH-1:0] pin_in = '0;
  logic [NCH-1:0] pin_out, pin_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = !clk;

  ccu_array #(.NCH(NCH), .CNT_W(CW), .ADDR_W(AW)) i_ccu_array (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
    .ch_pin_in(pin_in), .ch_pin_out(pin_out), .ch_pin_oe(pin_oe), .irq(irq)
  );

  // reference model state
  int        mcnt;
  bit        mrun, movie, mblk, movf;
  bit [6:0]  mm [NCH];
  int        mv [NCH];
  bit [NCH-1:0] mf, mtog, s1, s2, s3;
  int        pk, nv;
  bit        hit, fwr;

  // 0 idle, 1 capture, 2 timer, 3 toggle, 4 pwm
  function automatic int kind_of(bit [6:0] m);
    bit [5:0] b = m[5:0];
    if (b[5:2] == 4'b0000 && b[1:0] != 2'b00) return 1;
    if (b == 6'b001100) return 2;
    if (b == 6'b011100) return 3;
    if (b == 6'b100100) return 4;
    return 0;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic int model_rd(int a);
    if (a == 0) return {mblk, movie, mrun};
    if (a == 1) return {movf, mf};
    if (a >= 2 && a < 2 + NCH) return mm[a-2];
    if (a >= 2 + NCH && a < 2 + 2*NCH) return mv[a-2-NCH];
    if (a == 2 + 2*NCH) return mcnt;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt = 0; mrun = 0; movie = 0; mblk = 0; movf = 0;
      mf = '0; mtog = '0; s1 = '0; s2 = '0; s3 = '0;
      for (int c = 0; c < NCH; c++) begin mm[c] = '0; mv[c] = 0; end
    end else begin
      fwr = bus_wr && bus_addr == 1;
      for (int c = 0; c < NCH; c++) begin
        pk = kind_of(mm[c]);
        hit = 0;
        nv = mv[c];
        if (pk == 1 && ((mm[c][0] && s2[c] && !s3[c]) || (mm[c][1] && !s2[c] && s3[c]))) begin
          nv = mcnt; hit = 1;
        end else if (pk == 4 && mrun && (mcnt % 256) == 255)
          nv = (mv[c] & 'hFF00) | ((mv[c] >> 8) & 'hFF);
        else if (bus_wr && bus_addr == 2 + NCH + c)
          nv = bus_wdata;
        if ((pk == 2 || pk == 3) && mrun && mcnt == mv[c]) begin
          hit = 1;
          if (pk == 3) mtog[c] = !mtog[c];
        end
        if (hit) mf[c] = 1;
        else if (fwr && !bus_wdata[c]) mf[c] = 0;
        mv[c] = nv;
        if (bus_wr && bus_addr == 2 + c) mm[c] = bus_wdata[6:0];
        s3[c] = s2[c]; s2[c] = s1[c]; s1[c] = pin_in[c];
      end
      if (mrun && mcnt == 65535) movf = 1;
      else if (fwr && !bus_wdata[NCH]) movf = 0;
      if (mrun) mcnt = (mcnt + 1) % 65536;
      if (bus_wr && bus_addr == 0) {mblk, movie, mrun} = bus_wdata[2:0];
    end
  end

  // per-clock comparison of pins and interrupt against the model
  int  ck;
  bit  eo, ev, ei;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        ck = kind_of(mm[c]);
        eo = (ck == 3 || ck == 4);
        ev = (ck == 4) ? ((mcnt % 256) >= (mv[c] % 256)) : ((ck == 3) ? mtog[c] : 1'b0);
        checks++;
        if (pin_oe[c] !== eo || pin_out[c] !== ev) begin
          errors++;
          $display("FAIL %s ch%0d oe/out actual %b/%b expected %b/%b",
                   tag_of(ck), c, pin_oe[c], pin_out[c], eo, ev);
        end
      end
      ei = 0;
      for (int c = 0; c < NCH; c++) if (mf[c] && mm[c][6]) ei = 1;
      if (movf && movie) ei = 1;
      ei = ei && gie && mblk;
      checks++;
      if (irq !== ei) begin
        errors++;
        $display("FAIL R6 irq actual %b expected %b", irq, ei);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = CW'(d);
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input int a, input string tag);
    int e;
    @(negedge clk); #1;
    bus_addr = AW'(a);
    #0.5;
    e = model_rd(a);
    checks++;
    if (bus_rdata !== CW'(e)) begin
      errors++;
      $display("FAIL %s read addr %0d actual %h expected %h", tag, a, bus_rdata, CW'(e));
    end
  endtask

  task automatic pin(input int c, input bit v);
    @(negedge clk); #1;
    pin_in[c] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_bit(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(4);
    // R9 reset state
    for (int a = 0; a < 13; a++) rd(a, "R9");
    expect_bit(irq, 0, "R9", "irq after reset");
    expect_bit(|pin_oe, 0, "R9", "pin drive after reset");

    // R1 counter holds while stopped, then runs
    idle(5);
    rd(12, "R1");
    wr(0, 3'b101);
    gie = 1;
    idle(10);
    rd(12, "R1");

    // R3 timer on ch0 with irq enable, R6 irq
    rd(12, "R1");
    v = mcnt + 40;
    wr(7, v);
    wr(2, 7'b1001100);
    idle(50);
    rd(1, "R3");
    expect_bit(irq, 1, "R6", "irq after timer match");
    // R6 gating
    @(negedge clk); #1 gie = 0;
    idle(2);
    expect_bit(irq, 0, "R6", "irq with global enable low");
    @(negedge clk); #1 gie = 1;
    wr(0, 3'b001);
    idle(2);
    expect_bit(irq, 0, "R6", "irq with block enable low");
    wr(0, 3'b101);
    // R8 write of 1 keeps, write of 0 clears
    wr(1, 'hFFFF);
    rd(1, "R8");
    wr(1, 'hFFFE);
    rd(1, "R8");
    expect_bit(irq, 0, "R8", "irq after flag clear");

    // R7 irq enable bit does not change mode: timer without irq enable
    v = mcnt + 30;
    wr(7, v);
    wr(2, 7'b0001100);
    idle(40);
    rd(1, "R7");
    wr(1, 'hFFFE);

    // R4 toggle output on ch1, two matches
    v = mcnt + 30;
    wr(8, v);
    wr(3, 7'b0011100);
    idle(40);
    rd(1, "R4");
    v = mcnt + 20;
    wr(8, v);
    idle(30);
    rd(1, "R4");

    // R5 PWM on ch2, duty change deferred to low-byte wrap
    wr(9, 'h4040);
    wr(4, 7'b0100100);
    idle(300);
    wr(9, 'hC040);
    rd(9, "R5");
    idle(300);
    rd(9, "R5");
    wr(9, 'h0000);
    idle(300);

    // R2 capture rising on ch3, either edge on ch4
    wr(5, 7'b0000001);
    wr(6, 7'b0000011);
    pin(3, 1); pin(4, 1);
    idle(6);
    rd(10, "R2"); rd(11, "R2"); rd(1, "R2");
    wr(1, 'h0000);
    pin(3, 0); pin(4, 0);
    idle(6);
    rd(10, "R2"); rd(11, "R2"); rd(1, "R2");
    // falling-only on ch3
    wr(5, 7'b0000010);
    pin(3, 1); idle(6); rd(1, "R2");
    pin(3, 0); idle(6); rd(10, "R2"); rd(1, "R2");
    wr(1, 'h0000);

    // R7 idle combination: edges ignored, no drive
    wr(6, 7'b0111111);
    pin(4, 1); idle(6); pin(4, 0); idle(6);
    rd(1, "R7");
    rd(11, "R7");
    expect_bit(pin_oe[4], 0, "R7", "idle channel drive");

    // R8 hardware set wins over a clear in the same cycle
    v = mcnt + 20;
    wr(7, v);
    wr(2, 7'b1001100);
    do @(negedge clk); while (mcnt != v);
    #1 bus_wr = 1; bus_addr = 1; bus_wdata = 0;
    @(posedge clk); #1 bus_wr = 0;
    rd(1, "R8");
    expect_bit(bus_rdata[0], 1, "R8", "flag after set/clear collision");
    wr(1, 0);

    // R1 overflow flag after wrap, with overflow irq enabled
    wr(0, 3'b111);
    do @(negedge clk); while (!movf);
    idle(2);
    rd(1, "R1");
    expect_bit(irq, 1, "R6", "irq on overflow");
    wr(0, 3'b100);
    idle(5);
    rd(12, "R1");
    idle(5);
    rd(12, "R1");
    finish_run();
  end
endmodule